// File: doc/BRIEF.md
# Vector Table Address Remapper

This block sits on the address path between a CPU bus master and the system address decoder. It rewrites addresses that fall in the low window where the processor expects its exception vectors. Every other address passes through untouched. The remap is purely combinational, so it adds no cycle to the access path.

Two nested windows are handled, and each has its own control bit.
- **Vector window.** The outer window covers bytes 0x00–0xBF. It can be steered into SRAM, so that software can install its own handlers.
- **Boot window.** The inner window covers bytes 0x00–0x07 and holds the initial stack pointer and the reset entry. It is steered to a boot region until software sets a release bit.

Once both controls are cleared or set as appropriate, firmware can read the true flash contents at every low address.

The two control bits live in two 32-bit registers. A simple single-cycle register port reaches them: a write strobe, an address, write data, and combinational read data.

Top module: `vec_remap`

## Requirements
- R1: After reset, both control bits are 0 and both registers read 0. Addresses 0x00–0x07 map to BOOT_BASE plus offset, and 0x08–0xBF pass through unchanged.
- R2: Any address at or above 0xC0 appears on phys_addr unchanged.
- R3: While the vector flag (bit 0 of the register at 0x40000000) is 1, addresses 0x08–0xBF map to SRAM_BASE plus the same offset.
- R4: While the vector flag is 0, addresses 0x08–0xBF pass through unchanged.
- R5: While the boot release bit (bit 27 of the register at 0x40000004) is 0, addresses 0x00–0x07 map to BOOT_BASE plus the same offset, whatever the vector flag holds.
- R6: While the boot release bit is 1, addresses 0x00–0x07 follow the vector window rule. They map to SRAM_BASE plus offset if the vector flag is 1, and pass through if it is 0.
- R7: A write with reg_we=1 to 0x40000000 loads the vector flag from wdata bit 0, and one to 0x40000004 loads the release bit from wdata bit 27. A write to any other address changes neither bit, and any other address reads as 0.
- R8: All register bits other than the vector flag and the release bit read as 0, whatever was written to them.
- R9: phys_addr follows cpu_addr in the same cycle. A register write takes effect on phys_addr only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 32 | Address issued by the CPU |
| phys_addr | output | 32 | Translated address sent to the decoder |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 32 | Register port address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench keeps SRAM_BASE at 0x20000000 but overrides BOOT_BASE to 0x0E000000. This shows that the boot target is taken from the parameter and that the byte offset is kept inside that region.

The register addresses and bit positions stay at their defaults. With those values, every combination of the two control bits can be reached, along with both window edges (0x07/0x08 and 0xBF/0xC0). The bench also probes the cycle just before a write is captured and the cycle just after.

// File: rtl/vec_remap.sv
module vec_remap #(
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] BOOT_BASE  = 32'h1000_0000,
  parameter logic [31:0] CFG_ADDR   = 32'h4000_0000,
  parameter logic [31:0] SYS_ADDR   = 32'h4000_0004,
  parameter int          VEC_BYTES  = 192,
  parameter int          BOOT_BYTES = 8,
  parameter int          VIR_BIT    = 0,
  parameter int          REL_BIT    = 27
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cpu_addr,
  output logic [31:0] phys_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam logic [31:0] VEC_LIM  = 32'(VEC_BYTES);
  localparam logic [31:0] BOOT_LIM = 32'(BOOT_BYTES);

  logic vec_in_sram;
  logic boot_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_in_sram <= 1'b0;
      boot_rel    <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == CFG_ADDR) vec_in_sram <= reg_wdata[VIR_BIT];
      if (reg_addr == SYS_ADDR) boot_rel    <= reg_wdata[REL_BIT];
    end
  end

  wire in_vec  = cpu_addr < VEC_LIM;
  wire in_boot = cpu_addr < BOOT_LIM;

  assign phys_addr = (in_boot && !boot_rel) ? BOOT_BASE + cpu_addr :
                     (in_vec && vec_in_sram) ? SRAM_BASE + cpu_addr :
                     cpu_addr;

  assign reg_rdata = (reg_addr == CFG_ADDR) ? (32'(vec_in_sram) << VIR_BIT) :
                     (reg_addr == SYS_ADDR) ? (32'(boot_rel) << REL_BIT) :
                     32'h0;
endmodule

// File: rtl/vec_remap_chk.sv
module vec_remap_chk #(
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] BOOT_BASE  = 32'h1000_0000,
  parameter logic [31:0] CFG_ADDR   = 32'h4000_0000,
  parameter logic [31:0] SYS_ADDR   = 32'h4000_0004,
  parameter int          VEC_BYTES  = 192,
  parameter int          BOOT_BYTES = 8,
  parameter int          VIR_BIT    = 0,
  parameter int          REL_BIT    = 27
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cpu_addr,
  input logic [31:0] phys_addr,
  input logic        reg_we,
  input logic [31:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        vec_in_sram,
  input logic        boot_rel
);
  localparam logic [31:0] VEC_LIM  = 32'(VEC_BYTES);
  localparam logic [31:0] BOOT_LIM = 32'(BOOT_BYTES);

  a_r2_pass_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= VEC_LIM) |-> (phys_addr == cpu_addr));

  a_r3_sram_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_in_sram && cpu_addr >= BOOT_LIM && cpu_addr < VEC_LIM)
      |-> (phys_addr == SRAM_BASE + cpu_addr));

  a_r5_boot_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_rel && cpu_addr < BOOT_LIM) |-> (phys_addr == BOOT_BASE + cpu_addr));

  a_r7_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == CFG_ADDR) |=> (vec_in_sram == $past(reg_wdata[VIR_BIT])));

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we) |=> ($stable(vec_in_sram) && $stable(boot_rel)));

  a_r8_cfg_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CFG_ADDR) |-> ((reg_rdata & ~(32'h1 << VIR_BIT)) == 32'h0));

  a_r8_sys_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == SYS_ADDR) |-> ((reg_rdata & ~(32'h1 << REL_BIT)) == 32'h0));
endmodule

bind vec_remap vec_remap_chk #(
  .SRAM_BASE(SRAM_BASE), .BOOT_BASE(BOOT_BASE), .CFG_ADDR(CFG_ADDR),
  .SYS_ADDR(SYS_ADDR), .VEC_BYTES(VEC_BYTES), .BOOT_BYTES(BOOT_BYTES),
  .VIR_BIT(VIR_BIT), .REL_BIT(REL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .vec_in_sram(vec_in_sram), .boot_rel(boot_rel)
);

// File: tb/vec_remap_test.sv
`timescale 1ns/1ps
module vec_remap_test;
  localparam logic [31:0] SRAM = 32'h2000_0000;
  localparam logic [31:0] BOOT = 32'h0E00_0000;
  localparam logic [31:0] CFG  = 32'h4000_0000;
  localparam logic [31:0] SYS  = 32'h4000_0004;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] cpu_addr = 0;
  logic [31:0] phys_addr;
  logic        reg_we = 0;
  logic [31:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];
  event        ev;

  bit m_vir = 0;
  bit m_rel = 0;

  always #10 clk = ~clk;

  vec_remap #(.SRAM_BASE(SRAM), .BOOT_BASE(BOOT)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] model(input logic [31:0] a);
    if (a < 8 && !m_rel) return BOOT + a;
    if (a < 192 && m_vir) return SRAM + a;
    return a;
  endfunction

  task automatic probe(input logic [31:0] a, input string tag);
    cpu_addr = a;
    exp_q.push_back(model(a));
    kind_q.push_back(1'b0);
    tag_q.push_back(tag);
    ->ev;
    #2;
  endtask

  task automatic probe_rd(input logic [31:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    exp_q.push_back(e);
    kind_q.push_back(1'b1);
    tag_q.push_back(tag);
    ->ev;
    #2;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_we = 0;
    if (a == CFG) m_vir = d[0];
    if (a == SYS) m_rel = d[27];
  endtask

  initial begin
    forever begin
      @(ev);
      #1;
      begin
        logic [31:0] e, got;
        bit k;
        string t;
        e = exp_q.pop_front();
        k = kind_q.pop_front();
        t = tag_q.pop_front();
        got = k ? reg_rdata : phys_addr;
        checks++;
        if (got !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, got, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    @(negedge clk);
    probe_rd(CFG, 32'h0, "R1 cfg reset");
    probe_rd(SYS, 32'h0, "R1 sys reset");
    probe(32'h0, "R1 boot 0x00");
    probe(32'h4, "R1 boot 0x04");
    probe(32'h8, "R1 pass 0x08");
    probe(32'hBC, "R4 pass 0xBC");
    probe(32'hC0, "R2 pass 0xC0");
    probe(32'h2000_0010, "R2 pass high");

    wr(CFG, 32'hFFFF_FFFF);
    probe_rd(CFG, 32'h1, "R8 cfg bits");
    probe(32'h8, "R3 sram 0x08");
    probe(32'hBF, "R3 sram 0xBF");
    probe(32'hC0, "R2 edge with flag");
    probe(32'h3, "R5 boot priority");
    probe(32'h7, "R5 boot 0x07");

    wr(SYS, 32'hFFFF_FFFF);
    probe_rd(SYS, 32'h0800_0000, "R8 sys bits");
    probe(32'h0, "R6 released to sram 0x00");
    probe(32'h7, "R6 released to sram 0x07");

    wr(CFG, 32'h0);
    probe(32'h0, "R6 released flash 0x00");
    probe(32'h50, "R4 flash 0x50");

    wr(32'h4000_0008, 32'hFFFF_FFFF);
    probe_rd(32'h4000_0008, 32'h0, "R7 unmapped read");
    probe_rd(CFG, 32'h0, "R7 cfg untouched");
    probe_rd(SYS, 32'h0800_0000, "R7 sys untouched");
    probe(32'h20, "R7 map untouched");

    @(negedge clk);
    reg_we = 1; reg_addr = CFG; reg_wdata = 32'h1;
    probe(32'h20, "R9 before edge");
    @(posedge clk);
    #1;
    reg_we = 0;
    m_vir = 1;
    probe(32'h20, "R9 after edge");
    probe(32'h21, "R9 same cycle follow");

    wr(SYS, 32'h0);
    probe(32'h1, "R5 boot again");

    #5;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule